// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counting Timer

This block is a memory-mapped timer peripheral. A single 16-bit prescaler divides the system clock into a common tick. A parameterised number of 32-bit channels counts down on that tick. A channel expires when its count would drop below zero. On expiry it can raise its own interrupt line and latch a sticky pending flag. It then either reloads from its reload register and keeps running, or stops.

Software reaches the block through a plain 32-bit word port made of an address, a write enable, write data and registered read data.

The unit registers occupy slot 0 of a 16-byte-per-slot map. Channel n occupies slot n+1. Within a slot, word 0 is the counter (the prescaler value in slot 0) and word 1 is the reload value. Word 2 is the channel control register, or the read-only capability word in slot 0.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every prescaler and channel register reads 0, the capability word reads its fixed value, and all interrupt outputs are low.
- R2: The prescaler value register (offset 0x00) and the prescaler reload register (offset 0x04) keep only the low 16 bits of write data; the upper bits read as 0.
- R3: The prescaler counts down once per clock and emits a one-cycle tick as it passes zero, then reloads. Ticks therefore come every (reload+1) clocks. A running auto-restart channel with reload N signals every (N+1)*(P+1) clocks, where P is the prescaler reload.
- R4: A channel expires on the tick after its counter reaches 0. With the prescaler reload at 0, a control write at clock edge E that loads N and enables the channel drives the interrupt high in the cycle following edge E+N+1.
- R5: On expiry with interrupt enable set (control bit 3), the pending flag (control bit 4) is set and the channel's interrupt output is high for exactly one cycle per expiry. With interrupt enable clear, neither happens.
- R6: A control write with bit 4 set clears the pending flag. With bit 4 clear, the write leaves the flag unchanged.
- R7: A control write with the load bit (bit 2) set copies the reload register into the counter. The load bit, chain bit (5) and halt bit (6) always read as 0 and have no effect. The enable bit is bit 0 and the auto-restart bit is bit 1.
- R8: A write to a channel's counter (slot word 0) sets the count, and an enabled channel counts on from that value. N+1 ticks after the write, the channel expires.
- R9: On expiry with auto-restart clear, the channel stops: its enable bit reads 0 and its counter reads 0. With auto-restart set, it reloads and keeps running.
- R10: The capability word (offset 0x08) is read-only. Bits 2:0 hold the channel count modulo 8, bits 7:3 hold the interrupt base line, and bits 8 and 9 are set. With 2 channels and base line 8 it reads 0x342.
- R11: Reads of word 3 of any slot, or of slots beyond the configured channel count, return 0, and writes to them change nothing.
- R12: A disabled channel holds its counter value.
- R13: Each channel drives its own interrupt output bit. An expiry on one channel leaves the other channels' lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (8) | Byte address of the word accessed |
| wr_en | input | 1 | Write strobe for the addressed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address presented one cycle earlier |
| irq | output | NUM_CH (2) | Per-channel interrupt pulses |

## Verification
A counter that decrements one tick too early or too late shifts the interrupt pulse by one cycle. The bench times that pulse from the load edge, so the error shows within N+2 cycles of loading. A prescaler that reloads incorrectly changes the interval between successive auto-restart pulses, and the fault appears by the second pulse. A pending flag or enable bit left in the wrong state shows on the next control read-back, one cycle after the address is presented. A decode error shows as a nonzero read from an unmapped word, or as a changed register after a write that should have been ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 32;
  localparam int CB_EN = 0;
  localparam int CB_AR = 1;
  localparam int CB_LD = 2;
  localparam int CB_IE = 3;
  localparam int CB_IP = 4;
  localparam logic [1:0] W_CNT = 2'd0;
  localparam logic [1:0] W_RLD = 2'd1;
  localparam logic [1:0] W_CTL = 2'd2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_val,
  input  logic            wr_rld,
  input  logic [PS_W-1:0] wdata,
  output logic [PS_W-1:0] ps_val,
  output logic [PS_W-1:0] ps_rld,
  output logic            tick
);
  assign tick = (ps_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_val <= '0;
      ps_rld <= '0;
    end else begin
      if (wr_rld) ps_rld <= wdata;
      if (wr_val)    ps_val <= wdata;
      else if (tick) ps_val <= ps_rld;
      else           ps_val <= ps_val - 1'b1;
    end
  end

  // R3: after a tick with no direct write, the value restarts from the reload
  a_r3_reload_after_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_val && !wr_rld) |=> (ps_val == $past(ps_rld)));
  // R3: between ticks the value steps down by exactly one
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_val) |=> (ps_val == $past(ps_val) - 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [BUS_W-1:0] wdata,
  output logic [CW-1:0]    cnt_o,
  output logic [CW-1:0]    rld_o,
  output logic [BUS_W-1:0] ctl_o,
  output logic             irq_o
);
  logic en, ar, ie, pend;
  logic expire;
  logic [BUS_W-1:0] unused_wdata;

  assign unused_wdata = wdata;
  assign expire = en && tick && (cnt_o == '0);
  assign ctl_o  = BUS_W'({pend, ie, 1'b0, ar, en});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      rld_o <= '0;
      en    <= 1'b0;
      ar    <= 1'b0;
      ie    <= 1'b0;
      pend  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= expire && ie;
      if (wr_rld) rld_o <= wdata[CW-1:0];
      if (wr_ctl) begin
        en <= wdata[CB_EN];
        ar <= wdata[CB_AR];
        ie <= wdata[CB_IE];
      end else if (expire && !ar) begin
        en <= 1'b0;
      end
      if (expire && ie)               pend <= 1'b1;
      else if (wr_ctl && wdata[CB_IP]) pend <= 1'b0;
      if (wr_ctl && wdata[CB_LD]) cnt_o <= rld_o;
      else if (wr_cnt)            cnt_o <= wdata[CW-1:0];
      else if (expire)            cnt_o <= ar ? rld_o : '0;
      else if (en && tick)        cnt_o <= cnt_o - 1'b1;
    end
  end

  // R5: interrupt output only comes with a pending flag latched
  a_r5_irq_has_pend: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> pend);
  // R5: pending rises only from an enabled expiry
  a_r5_pend_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(en && tick && (cnt_o == '0) && ie));
  // R9: one-shot expiry stops the channel
  a_r9_one_shot_stop: assert property (@(posedge clk) disable iff (rst)
    (en && tick && (cnt_o == '0) && !ar && !wr_ctl) |=> !en);
  // R12: a disabled channel with no writes holds its count
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_cnt && !wr_ctl) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CW       = 32,
  parameter int PS_W     = 16,
  parameter int IRQ_BASE = 8,
  parameter int AW       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int SLOT_W = AW - 4;
  localparam logic [BUS_W-1:0] UNIT_CFG =
    BUS_W'(NUM_CH % 8) | (BUS_W'(IRQ_BASE % 32) << 3) | BUS_W'(32'h300);

  logic [SLOT_W-1:0] slot;
  logic [1:0]        word;
  logic [1:0]        unused_lsb;
  logic              unmapped;
  logic [PS_W-1:0]   ps_val, ps_rld;
  logic              tick;
  logic [CW-1:0]     ch_cnt [NUM_CH];
  logic [CW-1:0]     ch_rld [NUM_CH];
  logic [BUS_W-1:0]  ch_ctl [NUM_CH];
  logic [BUS_W-1:0]  rd_next;

  assign slot       = addr[AW-1:4];
  assign word       = addr[3:2];
  assign unused_lsb = addr[1:0];
  assign unmapped   = (word == 2'd3) || (32'(slot) > NUM_CH);

  tmr_prescaler #(.PS_W(PS_W)) i_ps (
    .clk(clk), .rst(rst),
    .wr_val(wr_en && slot == '0 && word == W_CNT),
    .wr_rld(wr_en && slot == '0 && word == W_RLD),
    .wdata(wdata[PS_W-1:0]),
    .ps_val(ps_val), .ps_rld(ps_rld), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en && (slot == SLOT_W'(g + 1));
    tmr_channel #(.CW(CW)) i_ch (
      .clk(clk), .rst(rst), .tick(tick),
      .wr_cnt(sel && word == W_CNT),
      .wr_rld(sel && word == W_RLD),
      .wr_ctl(sel && word == W_CTL),
      .wdata(wdata),
      .cnt_o(ch_cnt[g]), .rld_o(ch_rld[g]), .ctl_o(ch_ctl[g]),
      .irq_o(irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (slot == '0) begin
      case (word)
        W_CNT:   rd_next = BUS_W'(ps_val);
        W_RLD:   rd_next = BUS_W'(ps_rld);
        W_CTL:   rd_next = UNIT_CFG;
        default: rd_next = '0;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (slot == SLOT_W'(i + 1)) begin
        case (word)
          W_CNT:   rd_next = BUS_W'(ch_cnt[i]);
          W_RLD:   rd_next = BUS_W'(ch_rld[i]);
          W_CTL:   rd_next = ch_ctl[i];
          default: rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R11: unmapped addresses read back as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (rdata == '0));
  // R10: capability word is constant whenever it is read
  a_r10_cfg_const: assert property (@(posedge clk) disable iff (rst)
    (slot == '0 && word == W_CTL) |=> (rdata == UNIT_CFG));
endmodule

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = 0;
  logic        wr_en = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int tests = 0, fails = 0, cyc = 0;
  logic done = 0;

  tmr_unit i_tmr_unit (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {write, addr, wdata, expected readback}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'hABCD1234, 32'h00001234}, // R2 reload truncated
    {1'b1, 8'h04, 32'h00000000, 32'h00000000}, // R2
    {1'b1, 8'h00, 32'hFFFF0000, 32'h00000000}, // R2 value truncated
    {1'b1, 8'h08, 32'hFFFFFFFF, 32'h00000342}, // R10 read-only
    {1'b1, 8'h14, 32'h00000055, 32'h00000055}, // R7 reload reg
    {1'b1, 8'h18, 32'h0000007E, 32'h0000000A}, // R7 load/chain/halt read 0
    {1'b0, 8'h10, 32'h00000000, 32'h00000055}, // R7 load copied
    {1'b1, 8'h30, 32'h00001234, 32'h00000000}, // R11 beyond channels
    {1'b1, 8'h0C, 32'h00000005, 32'h00000000}, // R11 word 3
    {1'b1, 8'h1C, 32'h00000005, 32'h00000000}, // R11 word 3 of channel
    {1'b0, 8'h10, 32'h00000000, 32'h00000055}, // R12 R11 counter unchanged
    {1'b1, 8'h24, 32'h00000007, 32'h00000007}  // channel 1 reload
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 300) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [31:0] v;
    int n, t1, t2;
    logic other;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {30'b0, irq}, 32'h0);
    rd(8'h14, v); check("R1 ch0 reload", v, 0);
    rd(8'h18, v); check("R1 ch0 ctl", v, 0);
    rd(8'h28, v); check("R1 ch1 ctl", v, 0);
    rd(8'h08, v); check("R1 cfg", v, 32'h342);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check($sformatf("vec%0d R2/R7/R10/R11/R12", i), v, VEC[i][31:0]);
    end

    // R4 underflow timing, R5 single pulse, R9 one-shot stop
    wr(8'h14, 3);
    wr(8'h18, 32'h0D);
    check("R4 irq low right after load", {31'b0, irq[0]}, 0);
    wait_irq(0, n);
    check("R4 ticks to expiry", n, 4);
    @(negedge clk);
    check("R5 one-cycle pulse", {31'b0, irq[0]}, 0);
    rd(8'h18, v); check("R9 R5 ctl after one-shot", v, 32'h18);
    rd(8'h10, v); check("R9 counter after one-shot", v, 0);

    // R6 pending sticky / write-1 clear
    wr(8'h18, 32'h08);
    rd(8'h18, v); check("R6 bit4=0 keeps pending", v, 32'h18);
    wr(8'h18, 32'h10);
    rd(8'h18, v); check("R6 bit4=1 clears pending", v, 32'h00);

    // R5 no interrupt when disabled
    wr(8'h14, 2);
    wr(8'h18, 32'h05);
    other = 0;
    repeat (10) begin @(negedge clk); other |= irq[0]; end
    check("R5 no irq with ie=0", {31'b0, other}, 0);
    rd(8'h18, v); check("R5 no pend with ie=0", v, 0);

    // R3 prescaler period, R9 auto-restart, R13 separate lines
    wr(8'h04, 3);
    wr(8'h24, 4);
    wr(8'h28, 32'h0F);
    other = 0;
    wait_irq(1, n); t1 = cyc;
    while (irq[1]) begin @(negedge clk); other |= irq[0]; end
    while (!irq[1] && cyc < t1 + 200) begin @(negedge clk); other |= irq[0]; end
    t2 = cyc;
    check("R3 R9 auto-restart interval", t2 - t1, 20);
    check("R13 other line quiet", {31'b0, other}, 0);
    rd(8'h28, v); check("R5 R9 ch1 still running, pending", v, 32'h1B);
    wr(8'h28, 32'h10);
    wr(8'h04, 0);
    wr(8'h00, 0);

    // R12 hold while disabled, R8 counter write restarts
    wr(8'h10, 50);
    repeat (5) @(negedge clk);
    rd(8'h10, v); check("R12 disabled holds", v, 50);
    wr(8'h18, 32'h09);
    wr(8'h10, 2);
    wait_irq(0, n);
    check("R8 ticks from counter write", n, 3);

    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule